// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block is the digital back end of a two-channel 8-bit sampling converter. On every rising clock edge it captures one raw word per channel. The raw words are offset-binary codes. Both words pass through a fixed-length register pipeline. When a word enters the output register, it is recoded to offset binary or two's complement, depending on a format select input that is normally held static. Each output word is driven onto an 8-bit bus. An active-low enable controls that bus, and when it is not driving, the bus is released to high impedance.

The pipeline stalls when either of two low-power controls is raised: sleep or power-down. While it is stalled, the last output words stay on the buses. A valid flag drops during the stall. It comes back only after the pipeline has been refilled with a complete set of fresh samples. The separate data, drive-enable and valid outputs let the surrounding logic see exactly what the tri-stated buses carry.

Top module: `dual_adc_formatter`

## Requirements
- R1: A pair of words presented at rising edge n appears on `dout_a`/`dout_b` just after edge n+4 (five register stages, counting the capture register), with both channels captured on the same edge and delayed by the same amount.
- R2: With `fmt_twos` low, the output word equals the raw offset-binary word unchanged (raw 8'h80 gives 8'h80, 8'hFF gives 8'hFF, 8'h00 gives 8'h00).
- R3: With `fmt_twos` high, the output word is the raw word with bit 7 inverted and bits 6..0 unchanged (8'h80 gives 8'h00, 8'hFF gives 8'h7F, 8'h00 gives 8'h80, 8'h01 gives 8'h81).
- R4: `fmt_twos` is sampled at the edge on which a word moves into the output register, so a change of the select affects only the words that enter the output register after that change.
- R5: While `sleep` or `pwr_dn` is high at a rising edge, the pipeline does not advance, and `dout_a`/`dout_b` keep their previous values.
- R6: `data_valid` is low after any edge at which `sleep` or `pwr_dn` is high. It rises only after five consecutive advancing edges.
- R7: A rising edge with `rst_n` low sets both outputs and every pipeline stage to 8'h80 and clears `data_valid`.
- R8: With `oe_n` high, `drv_en` is low and both buses are released. With `oe_n` low, `drv_en` is high and `bus_a`/`bus_b` carry `dout_a`/`dout_b`. `oe_n` has no effect on pipeline contents.
- R9: `sleep` alone and `pwr_dn` alone have the same stalling and hold effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; rising edge captures and advances |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_a | input | 8 | Raw offset-binary word, channel A |
| samp_b | input | 8 | Raw offset-binary word, channel B |
| fmt_twos | input | 1 | 0 selects offset binary, 1 selects two's complement |
| oe_n | input | 1 | Active-low bus drive enable |
| sleep | input | 1 | Sleep request; stalls the pipeline |
| pwr_dn | input | 1 | Power-down request; stalls the pipeline |
| dout_a | output | 8 | Formatted channel A word (undriven view) |
| dout_b | output | 8 | Formatted channel B word (undriven view) |
| drv_en | output | 1 | High when the buses are driven |
| data_valid | output | 1 | High when the output words come from fresh samples |
| bus_a | inout | 8 | Tri-stated channel A bus |
| bus_b | inout | 8 | Tri-stated channel B bus |

## Verification
The hardest case to reach from the ports is a stall that begins while stale words are still in the pipeline. The outputs must then hold the exact word that was current at the stall, and the valid flag must stay low across a partial refill. The stimulus enters power-down and sleep at arbitrary points in a running stream. It also releases and re-asserts them after only two or three advancing edges. In addition, it flips the format select between the entry of two successive words into the output register. The bench model keeps the full history of advanced samples, so it predicts both the held word and the mixed-format words cycle by cycle.

// File: rtl/adc_fmt_pkg.sv
// Package: shared widths, latency, code constants and the output recoding
// function for the dual-channel formatter.
// Assumes raw words arrive as offset-binary codes.
package adc_fmt_pkg;
    localparam int SAMPLE_W = 8;
    localparam int LATENCY  = 5;
    localparam int NUM_CH   = 2;

    typedef logic [SAMPLE_W-1:0] sample_t;

    localparam sample_t MID_CODE = sample_t'(1) << (SAMPLE_W - 1);

    // Offset binary to two's complement is a flip of the top bit only.
    function automatic sample_t recode(input sample_t raw, input logic twos);
        sample_t r;
        r = raw;
        if (twos) r[SAMPLE_W-1] = ~raw[SAMPLE_W-1];
        return r;
    endfunction
endpackage

// File: rtl/fmt_lane.sv
// Module: one channel of the formatter. Holds LAT-1 capture/delay stages and
// the output register. The output register applies the coding at entry.
// Assumes LAT >= 2. adv low freezes every stage, including the output register.
module fmt_lane
    import adc_fmt_pkg::*;
#(
    parameter int LAT = LATENCY
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv,
    input  logic    fmt_twos,
    input  sample_t samp,
    output sample_t q
);
    localparam int NSTG = LAT - 1;
    localparam int TOP  = SAMPLE_W - 1;

    sample_t stg [NSTG];

    // Purpose: shift the sample chain and load the formatted output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTG; i++) stg[i] <= MID_CODE;
            q <= MID_CODE;
        end else if (adv) begin
            stg[0] <= samp;
            for (int i = 1; i < NSTG; i++) stg[i] <= stg[i-1];
            q <= recode(stg[NSTG-1], fmt_twos);
        end
    end

    assert_reset_mid_R7: assert property (@(posedge clk) !rst_n |=> (q == MID_CODE));

    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q));

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !fmt_twos) |=> (q == $past(stg[NSTG-1])));

    assert_twos_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && fmt_twos) |=> ((q[TOP] != $past(stg[NSTG-1][TOP])) &&
                               (q[TOP-1:0] == $past(stg[NSTG-1][TOP-1:0]))));
endmodule

// File: rtl/fresh_tracker.sv
// Module: tracks how many consecutive advancing edges have passed.
// valid rises once LAT fresh samples have filled the chain.
// Assumes LAT >= 2. Any frozen edge discards all freshness.
module fresh_tracker
    import adc_fmt_pkg::*;
#(
    parameter int LAT = LATENCY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic valid
);
    logic [LAT-1:0] fresh;

    // Purpose: shift in a fresh mark per advance, and wipe all marks on reset or stall.
    always_ff @(posedge clk) begin
        if (!rst_n)   fresh <= '0;
        else if (adv) fresh <= {fresh[LAT-2:0], 1'b1};
        else          fresh <= '0;
    end

    assign valid = fresh[LAT-1];

    assert_frozen_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> !valid);

    assert_valid_after_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(adv));
endmodule

// File: rtl/dual_adc_formatter.sv
// Module: top of the dual-channel output formatter. Two lanes share one
// advance control (either stall request freezes both) and one freshness tracker.
// The tri-stated buses are driven from the lane outputs under an active-low enable.
// Assumes fmt_twos is quasi-static. The enable path is combinational.
module dual_adc_formatter
    import adc_fmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] samp_a,
    input  logic [SAMPLE_W-1:0] samp_b,
    input  logic                fmt_twos,
    input  logic                oe_n,
    input  logic                sleep,
    input  logic                pwr_dn,
    output logic [SAMPLE_W-1:0] dout_a,
    output logic [SAMPLE_W-1:0] dout_b,
    output logic                drv_en,
    output logic                data_valid,
    inout  wire  [SAMPLE_W-1:0] bus_a,
    inout  wire  [SAMPLE_W-1:0] bus_b
);
    logic    adv;
    sample_t lane_in  [NUM_CH];
    sample_t lane_out [NUM_CH];

    // Purpose: either stall request halts the whole pipeline.
    assign adv = !(sleep || pwr_dn);

    assign lane_in[0] = samp_a;
    assign lane_in[1] = samp_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        fmt_lane #(.LAT(LATENCY)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (adv),
            .fmt_twos(fmt_twos),
            .samp    (lane_in[ch]),
            .q       (lane_out[ch])
        );
    end

    fresh_tracker #(.LAT(LATENCY)) u_fresh (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .valid(data_valid)
    );

    assign dout_a = lane_out[0];
    assign dout_b = lane_out[1];

    // Purpose: the output enable drives or releases both buses.
    assign drv_en = !oe_n;
    assign bus_a  = drv_en ? dout_a : {SAMPLE_W{1'bz}};
    assign bus_b  = drv_en ? dout_b : {SAMPLE_W{1'bz}};

    assert_bus_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> ((bus_a == dout_a) && (bus_b == dout_b)));
endmodule

// File: tb/dual_adc_formatter_tb.sv
module dual_adc_formatter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] samp_a = 8'h00, samp_b = 8'h00;
    logic       fmt_twos = 1'b0, oe_n = 1'b0, sleep = 1'b0, pwr_dn = 1'b0;
    logic [7:0] dout_a, dout_b;
    logic       drv_en, data_valid;
    wire  [7:0] bus_a, bus_b;

    int checks = 0;
    int failures = 0;
    string tag = "R7";

    // reference model state
    logic [7:0] hist_a[$], hist_b[$];
    logic [7:0] exp_a = 8'h80, exp_b = 8'h80;
    int fresh = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_adc_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .samp_a(samp_a), .samp_b(samp_b),
        .fmt_twos(fmt_twos), .oe_n(oe_n), .sleep(sleep), .pwr_dn(pwr_dn),
        .dout_a(dout_a), .dout_b(dout_b), .drv_en(drv_en),
        .data_valid(data_valid), .bus_a(bus_a), .bus_b(bus_b)
    );

    function automatic logic [7:0] coded(input logic [7:0] raw, input logic twos);
        return twos ? (raw ^ 8'h80) : raw;
    endfunction

    // Behavioural model: a history of advanced samples and a freshness count.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist_a.delete(); hist_b.delete();
            for (int i = 0; i < LAT; i++) begin hist_a.push_back(8'h80); hist_b.push_back(8'h80); end
            exp_a = 8'h80; exp_b = 8'h80; fresh = 0;
        end else if (sleep || pwr_dn) begin
            fresh = 0;
        end else begin
            hist_a.push_back(samp_a); hist_b.push_back(samp_b);
            if (hist_a.size() > LAT) begin void'(hist_a.pop_front()); void'(hist_b.pop_front()); end
            exp_a = coded(hist_a[0], fmt_twos);
            exp_b = coded(hist_b[0], fmt_twos);
            if (fresh < LAT) fresh++;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(tag, dout_a, exp_a, "dout_a");
        chk(tag, dout_b, exp_b, "dout_b");
        chk(tag, {7'd0, data_valid}, {7'd0, fresh == LAT}, "data_valid");
        chk("R8", {7'd0, drv_en}, {7'd0, !oe_n}, "drv_en");
        if (!oe_n) begin
            chk("R8", bus_a, exp_a, "bus_a");
            chk("R8", bus_b, exp_b, "bus_b");
        end
    endtask

    // One cycle: check at the falling edge, then drive new inputs.
    task automatic step(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        check_all();
        samp_a = a; samp_b = b;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        tag = "R7";
        step(8'h11, 8'h22);
        rst_n = 1'b1;
        // R1/R2: offset-binary stream, distinct per channel
        tag = "R1";
        for (int i = 0; i < 20; i++) step(8'(i * 37 + 5), 8'(8'hF0 - i * 11));
        tag = "R2";
        step(8'h80, 8'h00); step(8'hFF, 8'h7F);
        for (int i = 0; i < 6; i++) step(8'(i * 3), 8'(i * 5));
        // R3: two's complement corner codes
        fmt_twos = 1'b1; tag = "R3";
        step(8'h80, 8'hFF); step(8'h00, 8'h01); step(8'h7F, 8'h81);
        for (int i = 0; i < 8; i++) step(8'($urandom), 8'($urandom));
        // R4: toggle the select between successive words
        tag = "R4";
        for (int i = 0; i < 8; i++) begin fmt_twos = ~fmt_twos; step(8'(i * 29), 8'(i * 53)); end
        fmt_twos = 1'b0;
        // R5: power-down with enable low holds outputs
        tag = "R5";
        pwr_dn = 1'b1;
        for (int i = 0; i < 6; i++) step(8'($urandom), 8'($urandom));
        pwr_dn = 1'b0;
        // R6: partial refill, then re-stall, then a full refill
        tag = "R6";
        for (int i = 0; i < 3; i++) step(8'(i + 100), 8'(i + 200));
        pwr_dn = 1'b1; step(8'h55, 8'hAA); pwr_dn = 1'b0;
        for (int i = 0; i < 8; i++) step(8'(i + 60), 8'(i + 160));
        // R9: sleep alone stalls the same way
        tag = "R9";
        sleep = 1'b1;
        for (int i = 0; i < 4; i++) step(8'($urandom), 8'($urandom));
        sleep = 1'b0;
        for (int i = 0; i < 7; i++) step(8'(i * 9), 8'(i * 13));
        // R8: bus released while the pipeline keeps running; also while stalled
        tag = "R8";
        oe_n = 1'b1;
        for (int i = 0; i < 6; i++) step(8'(i * 41), 8'(i * 43));
        pwr_dn = 1'b1; step(8'h12, 8'h34); step(8'h56, 8'h78); pwr_dn = 1'b0;
        oe_n = 1'b0;
        for (int i = 0; i < 7; i++) step(8'(i + 1), 8'(i + 2));
        // R7: reset in mid stream
        tag = "R7";
        rst_n = 1'b0; step(8'hEE, 8'hDD); step(8'hCC, 8'hBB);
        rst_n = 1'b1;
        tag = "R1";
        for (int i = 0; i < 8; i++) step(8'(i * 17), 8'(i * 19));
        @(negedge clk); check_all();
        finish_run();
    end
endmodule